// File: doc/BRIEF.md
# Branch Target Predictor with Split Direct, Indirect and Return Structures

The block proposes the next fetch address for a fetch PC that the predecoder has already classified as a direct jump, an indirect jump (not a return), a return or a call. Three structures are read together in the same cycle: a direct-mapped target table for ordinary branches, a second tagged table for indirect jumps whose index mixes the PC with a short history of recent indirect targets, and a circular return stack. A selector chooses one answer according to the branch kind. If the preferred structure has no entry, the target table answers. If that also misses, the sequential address PC+4 is used.

Training comes in on a resolve port that carries the branch PC, its kind, its real target and whether the fetch-time guess was wrong. An indirect jump that keeps going to one place stays in the target table. The indirect table receives an entry only after the branch has shown a second target. Each table entry records this in a sticky "many targets" flag. The prediction is combinational from registered state. Every update takes effect at the next rising edge.

Top module: `btp_top`

## Requirements
- R1: For kind 0 (direct) and kind 3 (call), a target-table entry whose tag matches gives `pred_target` = stored target with `pred_src` = 1. Otherwise `pred_target` = PC+4 with `pred_src` = 0. The target table is indexed by PC bits [5:2] and tagged by PC bits [31:6] at default sizes.
- R2: For kind 1 (indirect), a tag match in the indirect table wins with `pred_src` = 2. Otherwise the target table answers (`pred_src` = 1), and otherwise PC+4 (`pred_src` = 0).
- R3: For kind 2 (return), a non-empty return stack supplies its top entry with `pred_src` = 3. When the stack is empty, the target table answers, and otherwise PC+4.
- R4: A lookup with `lk_valid` high pushes PC+4 for a call and pops one entry for a return. With `lk_valid` low the stack is untouched.
- R5: The return stack holds 16 entries and wraps. After more than 16 pushes, the most recent 16 return addresses pop back in reverse order, and the stack then reads as empty.
- R6: A resolve with `rs_mispred` high writes the real target into the target table for direct, call and return branches. With `rs_mispred` low, no stored target changes.
- R7: A mispredicted indirect jump that misses the target table is written into the target table, not the indirect table. A branch that always resolves to its stored target never receives an indirect-table entry.
- R8: The indirect table index is PC bits [5:2] XOR a 4-bit history. Each resolved indirect jump, mispredicted or not, updates the history to (history << 1) XOR target bits [5:2]. Nothing else changes the history.
- R9: Whenever a resolve hits an entry and its target differs from the stored one, the entry's many-targets flag is set, even without a mispredict. A later mispredicted indirect resolve then allocates in the indirect table and leaves the target-table target unchanged. This also happens when the table hits with a differing target, or when the indirect table already hits.
- R10: Reset clears all table entries, empties the return stack and zeroes the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup is a real fetch; gates return-stack push and pop |
| lk_pc | input | PC_W | Fetch PC of the branch |
| lk_kind | input | 2 | 0 direct, 1 indirect, 2 return, 3 call |
| pred_target | output | PC_W | Predicted next fetch address |
| pred_src | output | 2 | 0 sequential, 1 target table, 2 indirect table, 3 return stack |
| rs_valid | input | 1 | Resolve record valid |
| rs_pc | input | PC_W | PC of the resolved branch |
| rs_kind | input | 2 | Kind of the resolved branch, same code as `lk_kind` |
| rs_target | input | PC_W | Real target of the resolved branch |
| rs_mispred | input | 1 | The fetch-time prediction was wrong |

## Verification
The properties assume that the resolve port reports one branch per cycle, and that the resolve for an indirect jump follows the lookup made with the same history. They also assume that `lk_kind` and `pred_src` carry only the four listed codes. The stimulus applies a lookup and a resolve in separate cycles. It chooses indirect targets whose bits [5:2] are zero, except where a history change is the intended effect, so that the expected index stays known. Return-stack checks start from reset, so the stack depth the bench tracks matches the design's.

// File: rtl/btp_pkg.sv
package btp_pkg;

    typedef enum logic [1:0] {
        BR_DIRECT   = 2'd0,
        BR_INDIRECT = 2'd1,
        BR_RETURN   = 2'd2,
        BR_CALL     = 2'd3
    } br_kind_e;

    typedef enum logic [1:0] {
        SRC_SEQ = 2'd0,
        SRC_BTB = 2'd1,
        SRC_ITB = 2'd2,
        SRC_RAS = 2'd3
    } pred_src_e;

endpackage

// File: rtl/btp_tgt_table.sv
module btp_tgt_table #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    parameter int TAG_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic [PC_W-1:0]  rd_tgt,
    input  logic             up_en,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] up_idx,
    input  logic [TAG_W-1:0] up_tag,
    input  logic [PC_W-1:0]  up_tgt,
    output logic             up_hit,
    output logic             up_poly,
    output logic             up_differs
);

    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic             vld;
        logic             poly;
        logic [TAG_W-1:0] tag;
        logic [PC_W-1:0]  tgt;
    } ent_t;

    ent_t tab_q [DEPTH];
    ent_t tab_d [DEPTH];
    ent_t rd_ent;
    ent_t up_ent;

    // lookup port and resolve-side probe
    always_comb begin
        rd_ent     = tab_q[rd_idx];
        rd_hit     = rd_ent.vld && (rd_ent.tag == rd_tag);
        rd_tgt     = rd_ent.tgt;
        up_ent     = tab_q[up_idx];
        up_hit     = up_ent.vld && (up_ent.tag == up_tag);
        up_poly    = up_ent.poly;
        up_differs = (up_ent.tgt != up_tgt);
    end

    // next-state: sticky many-targets flag, target overwrite, allocation
    always_comb begin
        tab_d = tab_q;
        if (up_en) begin
            if (up_hit) begin
                if (up_differs) begin
                    tab_d[up_idx].poly = 1'b1;
                end
                if (wr_en) begin
                    tab_d[up_idx].tgt = up_tgt;
                end
            end else if (wr_en) begin
                tab_d[up_idx].vld  = 1'b1;
                tab_d[up_idx].poly = 1'b0;
                tab_d[up_idx].tag  = up_tag;
                tab_d[up_idx].tgt  = up_tgt;
            end
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_ent
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tab_q[g] <= '0;
                end else begin
                    tab_q[g] <= tab_d[g];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/btp_ret_stack.sv
module btp_ret_stack #(
    parameter int PC_W  = 32,
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [PC_W-1:0]  push_val,
    output logic [PC_W-1:0]  top_val,
    output logic             nonempty,
    output logic [CNT_W-1:0] level
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [CNT_W-1:0] cnt;
    } rs_state_t;

    rs_state_t        st_q, st_d;
    logic [PC_W-1:0]  slot_q [DEPTH];
    logic [PC_W-1:0]  slot_d [DEPTH];
    logic [PTR_W-1:0] ptr_inc, ptr_dec;

    always_comb begin
        ptr_inc  = (st_q.ptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.ptr + 1'b1;
        ptr_dec  = (st_q.ptr == '0) ? PTR_W'(DEPTH - 1) : st_q.ptr - 1'b1;
        top_val  = slot_q[ptr_dec];
        nonempty = (st_q.cnt != '0);
        level    = st_q.cnt;
    end

    always_comb begin
        st_d   = st_q;
        slot_d = slot_q;
        if (push) begin
            slot_d[st_q.ptr] = push_val;
            st_d.ptr         = ptr_inc;
            if (st_q.cnt != CNT_W'(DEPTH)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (pop && nonempty) begin
            st_d.ptr = ptr_dec;
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    slot_q[g] <= '0;
                end else begin
                    slot_q[g] <= slot_d[g];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/btp_top.sv
module btp_top #(
    parameter int PC_W      = 32,
    parameter int BTB_IDX_W = 4,
    parameter int ITB_IDX_W = 4,
    parameter int RAS_DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_valid,
    input  logic [PC_W-1:0] lk_pc,
    input  logic [1:0]      lk_kind,
    output logic [PC_W-1:0] pred_target,
    output logic [1:0]      pred_src,
    input  logic            rs_valid,
    input  logic [PC_W-1:0] rs_pc,
    input  logic [1:0]      rs_kind,
    input  logic [PC_W-1:0] rs_target,
    input  logic            rs_mispred
);

    import btp_pkg::*;

    localparam int BTB_TAG_W = PC_W - BTB_IDX_W - 2;
    localparam int ITB_TAG_W = PC_W - ITB_IDX_W - 2;
    localparam int HIST_W    = ITB_IDX_W;
    localparam int CNT_W     = $clog2(RAS_DEPTH + 1);

    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } top_state_t;

    top_state_t st_q, st_d;

    br_kind_e          lk_k, rs_k;
    logic [PC_W-1:0]   lk_seq;
    logic [HIST_W-1:0] hist_cur;

    logic              btb_rd_hit, itb_rd_hit;
    logic [PC_W-1:0]   btb_rd_tgt, itb_rd_tgt;
    logic              btb_up_hit, btb_up_poly, btb_up_differs;
    logic              itb_up_hit, itb_up_poly, itb_up_differs;
    logic              btb_wr, itb_wr, itb_up_en, rs_ind, many_tgts;

    logic              ras_push, ras_pop, ras_nonempty;
    logic [PC_W-1:0]   ras_top;
    logic [CNT_W-1:0]  ras_cnt;

    logic [ITB_IDX_W-1:0] itb_rd_idx, itb_up_idx;

    always_comb begin
        lk_k       = br_kind_e'(lk_kind);
        rs_k       = br_kind_e'(rs_kind);
        lk_seq     = lk_pc + PC_W'(4);
        hist_cur   = st_q.hist;
        itb_rd_idx = lk_pc[ITB_IDX_W+1:2] ^ st_q.hist;
        itb_up_idx = rs_pc[ITB_IDX_W+1:2] ^ st_q.hist;
        ras_push   = lk_valid && (lk_k == BR_CALL);
        ras_pop    = lk_valid && (lk_k == BR_RETURN);
    end

    btp_tgt_table #(
        .PC_W (PC_W),
        .IDX_W(BTB_IDX_W),
        .TAG_W(BTB_TAG_W)
    ) u_btb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (lk_pc[BTB_IDX_W+1:2]),
        .rd_tag    (lk_pc[PC_W-1:BTB_IDX_W+2]),
        .rd_hit    (btb_rd_hit),
        .rd_tgt    (btb_rd_tgt),
        .up_en     (rs_valid),
        .wr_en     (btb_wr),
        .up_idx    (rs_pc[BTB_IDX_W+1:2]),
        .up_tag    (rs_pc[PC_W-1:BTB_IDX_W+2]),
        .up_tgt    (rs_target),
        .up_hit    (btb_up_hit),
        .up_poly   (btb_up_poly),
        .up_differs(btb_up_differs)
    );

    btp_tgt_table #(
        .PC_W (PC_W),
        .IDX_W(ITB_IDX_W),
        .TAG_W(ITB_TAG_W)
    ) u_itb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (itb_rd_idx),
        .rd_tag    (lk_pc[PC_W-1:ITB_IDX_W+2]),
        .rd_hit    (itb_rd_hit),
        .rd_tgt    (itb_rd_tgt),
        .up_en     (itb_up_en),
        .wr_en     (itb_wr),
        .up_idx    (itb_up_idx),
        .up_tag    (rs_pc[PC_W-1:ITB_IDX_W+2]),
        .up_tgt    (rs_target),
        .up_hit    (itb_up_hit),
        .up_poly   (itb_up_poly),
        .up_differs(itb_up_differs)
    );

    btp_ret_stack #(
        .PC_W (PC_W),
        .DEPTH(RAS_DEPTH)
    ) u_ras (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (ras_push),
        .pop     (ras_pop),
        .push_val(lk_seq),
        .top_val (ras_top),
        .nonempty(ras_nonempty),
        .level   (ras_cnt)
    );

    // selector: specialised structure first, target table next, then PC+4
    always_comb begin
        pred_target = lk_seq;
        pred_src    = SRC_SEQ;
        unique case (lk_k)
            BR_INDIRECT: begin
                if (itb_rd_hit) begin
                    pred_target = itb_rd_tgt;
                    pred_src    = SRC_ITB;
                end else if (btb_rd_hit) begin
                    pred_target = btb_rd_tgt;
                    pred_src    = SRC_BTB;
                end
            end
            BR_RETURN: begin
                if (ras_nonempty) begin
                    pred_target = ras_top;
                    pred_src    = SRC_RAS;
                end else if (btb_rd_hit) begin
                    pred_target = btb_rd_tgt;
                    pred_src    = SRC_BTB;
                end
            end
            default: begin
                if (btb_rd_hit) begin
                    pred_target = btb_rd_tgt;
                    pred_src    = SRC_BTB;
                end
            end
        endcase
    end

    // training policy and history next state
    always_comb begin
        rs_ind    = rs_valid && (rs_k == BR_INDIRECT);
        many_tgts = btb_up_hit && (btb_up_poly || btb_up_differs);
        itb_up_en = rs_ind;
        itb_wr    = rs_ind && rs_mispred && (itb_up_hit || many_tgts);
        btb_wr    = rs_valid && rs_mispred && !itb_wr;
        st_d      = st_q;
        if (rs_ind) begin
            st_d.hist = {st_q.hist[HIST_W-2:0], 1'b0} ^ rs_target[HIST_W+1:2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/btp_checker.sv
module btp_checker #(
    parameter int PC_W      = 32,
    parameter int RAS_DEPTH = 16,
    parameter int HIST_W    = 4,
    localparam int CNT_W    = $clog2(RAS_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [PC_W-1:0]   lk_pc,
    input logic [1:0]        lk_kind,
    input logic [PC_W-1:0]   pred_target,
    input logic [1:0]        pred_src,
    input logic              rs_valid,
    input logic [1:0]        rs_kind,
    input logic [HIST_W-1:0] hist,
    input logic [CNT_W-1:0]  ras_cnt
);

    AST_SEQ_IS_PC4: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_src == 2'd0) |-> (pred_target == lk_pc + PC_W'(4))); // R1

    AST_ITB_ONLY_IND: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_src == 2'd2) |-> (lk_kind == 2'd1)); // R2

    AST_RAS_ONLY_RET: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_src == 2'd3) |-> (lk_kind == 2'd2 && ras_cnt != '0)); // R3

    AST_RAS_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> $stable(ras_cnt)); // R4

    AST_CALL_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_kind == 2'd3 && ras_cnt != CNT_W'(RAS_DEPTH))
        |=> (ras_cnt == $past(ras_cnt) + 1'b1)); // R4

    AST_RAS_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ras_cnt <= CNT_W'(RAS_DEPTH)); // R5

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rs_valid && rs_kind == 2'd1) |=> $stable(hist)); // R8

endmodule

bind btp_top btp_checker #(
    .PC_W     (PC_W),
    .RAS_DEPTH(RAS_DEPTH),
    .HIST_W   (ITB_IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_pc      (lk_pc),
    .lk_kind    (lk_kind),
    .pred_target(pred_target),
    .pred_src   (pred_src),
    .rs_valid   (rs_valid),
    .rs_kind    (rs_kind),
    .hist       (hist_cur),
    .ras_cnt    (ras_cnt)
);

// File: tb/tb_btp_top.sv
module tb_btp_top;

    localparam int CYC = 8;
    localparam logic [1:0] K_DIR = 2'd0, K_IND = 2'd1, K_RET = 2'd2, K_CALL = 2'd3;
    localparam logic [1:0] S_SEQ = 2'd0, S_BTB = 2'd1, S_ITB = 2'd2, S_RAS = 2'd3;

    typedef struct packed {
        logic        lk_v;
        logic [31:0] lk_pc;
        logic [1:0]  lk_k;
        logic        rs_v;
        logic [31:0] rs_pc;
        logic [1:0]  rs_k;
        logic [31:0] rs_t;
        logic        rs_mp;
        logic [31:0] e_tgt;
        logic [1:0]  e_src;
        logic [7:0]  req;
    } vec_t;

    function automatic vec_t lk(input logic [31:0] pc, input logic [1:0] k,
                                input logic [31:0] et, input logic [1:0] es,
                                input logic [7:0] rq);
        vec_t v;
        v = '0;
        v.lk_v = 1'b1; v.lk_pc = pc; v.lk_k = k;
        v.e_tgt = et;  v.e_src = es; v.req = rq;
        return v;
    endfunction

    function automatic vec_t rs(input logic [31:0] pc, input logic [1:0] k,
                                input logic [31:0] t, input logic mp);
        vec_t v;
        v = '0;
        v.rs_v = 1'b1; v.rs_pc = pc; v.rs_k = k; v.rs_t = t; v.rs_mp = mp;
        return v;
    endfunction

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        lk(32'h100, K_DIR, 32'h104, S_SEQ, 8'd1),   // R1 cold miss
        rs(32'h100, K_DIR, 32'h400, 1'b1),          // R6 train
        lk(32'h100, K_DIR, 32'h400, S_BTB, 8'd1),   // R1 hit
        lk(32'h140, K_DIR, 32'h144, S_SEQ, 8'd1),   // R1 tag mismatch
        rs(32'h208, K_IND, 32'h800, 1'b1),          // R7 first target into table
        lk(32'h208, K_IND, 32'h800, S_BTB, 8'd7),   // R7
        rs(32'h208, K_IND, 32'h800, 1'b0),          // R7 same target again
        lk(32'h208, K_IND, 32'h800, S_BTB, 8'd7),   // R7 still no indirect entry
        rs(32'h208, K_IND, 32'hC00, 1'b1),          // R7 second target -> indirect table
        lk(32'h208, K_IND, 32'hC00, S_ITB, 8'd2),   // R2 indirect table wins
        lk(32'h208, K_DIR, 32'h800, S_BTB, 8'd7),   // R7 table target kept
        rs(32'h300, K_IND, 32'h904, 1'b0),          // R8 history becomes 1
        lk(32'h208, K_IND, 32'h800, S_BTB, 8'd8),   // R8 index moved, falls back
        lk(32'h500, K_CALL, 32'h504, S_SEQ, 8'd4),  // R4 push 0x504
        lk(32'h600, K_CALL, 32'h604, S_SEQ, 8'd4),  // R4 push 0x604
        lk(32'h700, K_RET, 32'h604, S_RAS, 8'd3),   // R3
        lk(32'h700, K_RET, 32'h504, S_RAS, 8'd3),   // R3
        lk(32'h700, K_RET, 32'h704, S_SEQ, 8'd3),   // R3 empty, table miss
        rs(32'h700, K_RET, 32'h540, 1'b1),          // R6
        lk(32'h700, K_RET, 32'h540, S_BTB, 8'd6),   // R6 return fallback
        rs(32'h700, K_RET, 32'h580, 1'b0),          // R6 no mispredict
        lk(32'h700, K_RET, 32'h540, S_BTB, 8'd6),   // R6 unchanged
        lk(32'h100, K_DIR, 32'h104, S_SEQ, 8'd6)    // R6 entry replaced by 0x700
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_pc = '0;
    logic [1:0]  lk_kind = '0;
    logic [31:0] pred_target;
    logic [1:0]  pred_src;
    logic        rs_valid = 1'b0;
    logic [31:0] rs_pc = '0;
    logic [1:0]  rs_kind = '0;
    logic [31:0] rs_target = '0;
    logic        rs_mispred = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CYC/2) clk = ~clk;

    btp_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_valid   (lk_valid),
        .lk_pc      (lk_pc),
        .lk_kind    (lk_kind),
        .pred_target(pred_target),
        .pred_src   (pred_src),
        .rs_valid   (rs_valid),
        .rs_pc      (rs_pc),
        .rs_kind    (rs_kind),
        .rs_target  (rs_target),
        .rs_mispred (rs_mispred)
    );

    task automatic check(input string rq, input logic [31:0] et, input logic [1:0] es);
        n_tests++;
        if (pred_target !== et || pred_src !== es) begin
            n_fail++;
            $display("FAIL %s: target %h src %0d, expected target %h src %0d",
                     rq, pred_target, pred_src, et, es);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        lk_valid   = v.lk_v;  lk_pc = v.lk_pc; lk_kind = v.lk_k;
        rs_valid   = v.rs_v;  rs_pc = v.rs_pc; rs_kind = v.rs_k;
        rs_target  = v.rs_t;  rs_mispred = v.rs_mp;
        #2;
        if (v.lk_v) check($sformatf("R%0d", v.req), v.e_tgt, v.e_src);
    endtask

    task automatic idle();
        apply('0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        lk_valid = 1'b0; rs_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(CYC * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state through lookups
        apply(lk(32'h100, K_DIR, 32'h104, S_SEQ, 8'd10));
        apply(lk(32'h208, K_IND, 32'h20C, S_SEQ, 8'd10));

        for (int i = 0; i < NV; i++) apply(VEC[i]);

        // R10 everything cleared after a second reset
        do_reset();
        apply(lk(32'h208, K_IND, 32'h20C, S_SEQ, 8'd10));
        apply(lk(32'h700, K_RET, 32'h704, S_SEQ, 8'd10));
        apply(lk(32'h100, K_DIR, 32'h104, S_SEQ, 8'd10));

        // R4 call seen with lk_valid low must not push
        @(negedge clk);
        lk_valid = 1'b0; lk_pc = 32'h2000; lk_kind = K_CALL; rs_valid = 1'b0;
        apply(lk(32'h3000, K_RET, 32'h3004, S_SEQ, 8'd4));

        // R5 seventeen calls, sixteen returns in reverse, then empty
        for (int i = 0; i < 17; i++) begin
            @(negedge clk);
            lk_valid = 1'b1; lk_pc = 32'h1000 + 32'(i) * 32'h40; lk_kind = K_CALL;
        end
        for (int j = 0; j < 16; j++) begin
            apply(lk(32'h3000, K_RET, 32'h1000 + 32'(16 - j) * 32'h40 + 32'h4, S_RAS, 8'd5));
        end
        apply(lk(32'h3000, K_RET, 32'h3004, S_SEQ, 8'd5));

        // R9 flag set by a non-mispredicted differing resolve drives allocation
        apply(rs(32'h20C, K_IND, 32'h800, 1'b1));
        apply(lk(32'h20C, K_IND, 32'h800, S_BTB, 8'd9));
        apply(rs(32'h20C, K_IND, 32'hC00, 1'b0));
        apply(lk(32'h20C, K_IND, 32'h800, S_BTB, 8'd9));
        apply(rs(32'h20C, K_IND, 32'h800, 1'b1));
        apply(lk(32'h20C, K_IND, 32'h800, S_ITB, 8'd9));

        idle();
        report();
    end

endmodule